// File: doc/BRIEF.md
# Per-Chunk SEC-DED Parity Engine for Page Storage

This block protects page data held in raw flash-style storage. A page is handled as a sequence of fixed 256-byte chunks, and every chunk has its own independent 22-bit code. Bytes arrive one per cycle with a valid strobe, and a last strobe marks the final byte of a chunk. While the bytes arrive, the engine builds two kinds of parity. Row parity is kept in pairs taken from each bit of the byte offset. Column parity is kept in pairs taken from each bit of the bit position inside a byte.

When a chunk ends, the engine presents a 24-bit parity word. On a write this word is stored next to the chunk. On a read the stored word is supplied on the same cycle as the last byte. The engine XORs it with the freshly computed code and sorts the result into one of four outcomes: clean, one flipped data bit (located by byte offset and bit index), one flipped parity bit, or uncorrectable. A page of 512 bytes is two chunks and a page of 2048 bytes is eight chunks. The engine numbers each chunk within the page and wraps at the parameterised chunk count.

Top module: `ecc_chunk_engine`

## Requirements
- R1: While reset is held and afterwards until the first chunk ends, `resultValid` is 0, `parityOut` is 0, `status` is 0 and `resultUnit` is 0. Reset also discards a partially received chunk.
- R2: `parityOut` bit 2k+1 (k = 0..7) is the XOR of every data bit in the bytes whose offset has bit k set. Bit 2k is the same XOR over the bytes whose offset has bit k clear. Bit 16+2j+1 (j = 0..2) is the XOR of the data bits, over all bytes, at positions whose bit j is set. Bit 16+2j is the same over positions whose bit j is clear. Bits 23:22 are always 1.
- R3: The parity word and the result appear in the cycle after the edge that accepts the last byte. `resultValid` is high for that single cycle, and the outputs hold until the next chunk ends.
- R4: A syndrome (stored XOR computed, bits 21:0) of all zeros gives `status` 0 (clean).
- R5: A syndrome in which every one of the 11 bit pairs (2p, 2p+1) has exactly one bit set gives `status` 1. `errByte` is then the odd row bits (syndrome bits 1,3,...,15 as errByte bits 0..7), and `errBit` is the odd column bits (syndrome bits 17,19,21).
- R6: A syndrome with exactly one set bit gives `status` 2 (parity damaged, data intact). For any status other than 1, `errByte` and `errBit` are 0.
- R7: Any other syndrome, including every pair of flipped data bits within a chunk, gives `status` 3 (uncorrectable).
- R8: Bits 23:22 of `storedParity` have no effect on the result.
- R9: The accumulators clear after the last byte, so each chunk's code depends only on its own 256 bytes.
- R10: `resultUnit` gives the chunk's position in the page. It starts at 0, steps by one per chunk and wraps to 0 after UNITS-1.
- R11: Cycles with `inValid` low are ignored, whatever `inData` and `inLast` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Byte on `inData` is accepted this cycle |
| inData | input | 8 | Data byte |
| inLast | input | 1 | Accepted byte is the final byte of the chunk |
| storedParity | input | 24 | Previously stored parity word, sampled with the last byte |
| resultValid | output | 1 | One-cycle pulse: chunk outputs are new |
| parityOut | output | 24 | Parity word computed over the chunk |
| status | output | 2 | 0 clean, 1 data bit correctable, 2 parity bit damaged, 3 uncorrectable |
| errByte | output | 8 | Byte offset of the flipped bit when status is 1 |
| errBit | output | 3 | Bit index of the flipped bit when status is 1 |
| resultUnit | output | 3 | Chunk number within the page |

## Verification
The checker watches the timing contract on every cycle. A last byte always yields a one-cycle result pulse, no pulse appears without one, and the outputs stay frozen between chunks. It also checks on every cycle that the pad bits read back as ones and that a location is reported only for a correctable data bit. Only the bench scenarios can show whether the parity word, the syndrome class and the reported location are correct. They do this for chosen bit flips at the chunk edges and in the middle, for double flips, for parity-only damage, for gapped input, for zeroed pad bits, for the wrap of the chunk number and for reset in the middle of a chunk.

// File: rtl/ecc_chunk_pkg.sv
`timescale 1ns/1ps
package ecc_chunk_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN         = 2'd0,
    ST_DATA_FIX      = 2'd1,
    ST_PARITY_FIX    = 2'd2,
    ST_UNCORRECTABLE = 2'd3
  } eccStatus_t;

  // strobes from control to datapath
  typedef struct packed {
    logic take;   // a byte is accepted this cycle
    logic close;  // the accepted byte ends the chunk
  } eccStrobe_t;

  // bit positions inside a byte whose index has bit j set
  function automatic logic [7:0] oddMask(input int j);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = ((b >> j) & 1) == 1;
    return m;
  endfunction

endpackage

// File: rtl/ecc_chunk_ctrl.sv
`timescale 1ns/1ps
module ecc_chunk_ctrl
  import ecc_chunk_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int UNITS  = 8,
  parameter int UNIT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inLast,
  output eccStrobe_t        strobe,
  output logic [IDX_W-1:0]  byteIdx,
  output logic [UNIT_W-1:0] resultUnit
);

  localparam logic [UNIT_W-1:0] LAST_UNIT = UNIT_W'(UNITS - 1);

  logic [UNIT_W-1:0] unitCnt;

  assign strobe.take  = inValid;
  assign strobe.close = inValid & inLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx    <= '0;
      unitCnt    <= '0;
      resultUnit <= '0;
    end else if (strobe.take) begin
      if (strobe.close) begin
        byteIdx    <= '0;
        resultUnit <= unitCnt;
        unitCnt    <= (unitCnt == LAST_UNIT) ? '0 : unitCnt + 1'b1;
      end else begin
        byteIdx <= byteIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ecc_chunk_datapath.sv
`timescale 1ns/1ps
module ecc_chunk_datapath
  import ecc_chunk_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int PAR_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  eccStrobe_t       strobe,
  input  logic [IDX_W-1:0] byteIdx,
  input  logic [7:0]       inData,
  input  logic [PAR_W-1:0] storedParity,
  output logic             resultValid,
  output logic [PAR_W-1:0] parityOut,
  output eccStatus_t       status,
  output logic [IDX_W-1:0] errByte,
  output logic [2:0]       errBit
);

  localparam int LINE_W = 2 * IDX_W;
  localparam int COL_W  = 6;
  localparam int CODE_W = LINE_W + COL_W;
  localparam int PAD_W  = PAR_W - CODE_W;
  localparam int PAIRS  = CODE_W / 2;

  logic [LINE_W-1:0] lineAcc, lineHit, lineNext;
  logic [7:0]        colAcc, colNext;
  logic [COL_W-1:0]  colPar;
  logic [CODE_W-1:0] codeNext, syn;
  logic [PAR_W-1:0]  parNext;
  logic [PAIRS-1:0]  pairOne;
  logic [IDX_W-1:0]  locByte;
  logic [2:0]        locBit;
  logic              bytePar;
  eccStatus_t        statusNext;
  logic              unusedPad;

  // row parity: a byte with odd weight toggles one bit of every pair
  assign bytePar = ^inData;
  for (genvar k = 0; k < IDX_W; k++) begin : g_line
    assign lineHit[2*k+1] = bytePar &  byteIdx[k];
    assign lineHit[2*k]   = bytePar & ~byteIdx[k];
    assign locByte[k]     = syn[2*k+1];
  end
  assign lineNext = lineAcc ^ lineHit;

  // column parity: fold the running XOR of all bytes at the end
  assign colNext = colAcc ^ inData;
  for (genvar j = 0; j < 3; j++) begin : g_col
    assign colPar[2*j+1]  = ^(colNext &  oddMask(j));
    assign colPar[2*j]    = ^(colNext & ~oddMask(j));
    assign locBit[j]      = syn[LINE_W+2*j+1];
  end

  assign codeNext = {colPar, lineNext};
  assign parNext  = {{PAD_W{1'b1}}, codeNext};

  // syndrome decode
  assign syn       = codeNext ^ storedParity[CODE_W-1:0];
  assign unusedPad = ^storedParity[PAR_W-1:CODE_W];
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign pairOne[p] = syn[2*p] ^ syn[2*p+1];
  end

  always_comb begin
    if (syn == '0)                  statusNext = ST_CLEAN;
    else if (&pairOne)              statusNext = ST_DATA_FIX;
    else if ($countones(syn) == 1)  statusNext = ST_PARITY_FIX;
    else                            statusNext = ST_UNCORRECTABLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineAcc     <= '0;
      colAcc      <= '0;
      resultValid <= 1'b0;
      parityOut   <= '0;
      status      <= ST_CLEAN;
      errByte     <= '0;
      errBit      <= '0;
    end else begin
      resultValid <= strobe.close;
      if (strobe.close) begin
        lineAcc   <= '0;
        colAcc    <= '0;
        parityOut <= parNext;
        status    <= statusNext;
        errByte   <= (statusNext == ST_DATA_FIX) ? locByte : '0;
        errBit    <= (statusNext == ST_DATA_FIX) ? locBit  : '0;
      end else if (strobe.take) begin
        lineAcc <= lineNext;
        colAcc  <= colNext;
      end
    end
  end

endmodule

// File: rtl/ecc_chunk_engine.sv
`timescale 1ns/1ps
module ecc_chunk_engine
  import ecc_chunk_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int UNITS  = 8,
  parameter int PAR_W  = 24,
  parameter int UNIT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        inData,
  input  logic              inLast,
  input  logic [PAR_W-1:0]  storedParity,
  output logic              resultValid,
  output logic [PAR_W-1:0]  parityOut,
  output logic [1:0]        status,
  output logic [IDX_W-1:0]  errByte,
  output logic [2:0]        errBit,
  output logic [UNIT_W-1:0] resultUnit
);

  eccStrobe_t       strobe;
  logic [IDX_W-1:0] byteIdx;
  eccStatus_t       statusQ;

  ecc_chunk_ctrl #(.IDX_W(IDX_W), .UNITS(UNITS), .UNIT_W(UNIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .strobe(strobe), .byteIdx(byteIdx), .resultUnit(resultUnit)
  );

  ecc_chunk_datapath #(.IDX_W(IDX_W), .PAR_W(PAR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteIdx(byteIdx),
    .inData(inData), .storedParity(storedParity),
    .resultValid(resultValid), .parityOut(parityOut), .status(statusQ),
    .errByte(errByte), .errBit(errBit)
  );

  assign status = statusQ;

endmodule

// File: rtl/ecc_chunk_engine_chk.sv
`timescale 1ns/1ps
module ecc_chunk_engine_chk #(
  parameter int IDX_W  = 8,
  parameter int UNITS  = 8,
  parameter int PAR_W  = 24,
  parameter int UNIT_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [7:0]        inData,
  input logic              inLast,
  input logic [PAR_W-1:0]  storedParity,
  input logic              resultValid,
  input logic [PAR_W-1:0]  parityOut,
  input logic [1:0]        status,
  input logic [IDX_W-1:0]  errByte,
  input logic [2:0]        errBit,
  input logic [UNIT_W-1:0] resultUnit
);

  localparam int CODE_W = 2 * IDX_W + 6;

  // R3: every final byte produces a result in the next cycle
  assert_close_reports_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inLast) |=> resultValid);

  // R3, R11: no result pulse without an accepted final byte
  assert_pulse_has_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(inValid && inLast));

  // R3: outputs hold between chunks
  assert_outputs_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inLast) |=> ($stable(parityOut) && $stable(status) && $stable(resultUnit)));

  // R2: pad bits of a produced word read as ones
  assert_pad_ones_R2: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (&parityOut[PAR_W-1:CODE_W]));

  // R6: a location is reported only for a correctable data bit
  assert_location_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && status != 2'd1) |-> (errByte == '0 && errBit == '0));

endmodule

bind ecc_chunk_engine ecc_chunk_engine_chk #(
  .IDX_W(IDX_W), .UNITS(UNITS), .PAR_W(PAR_W), .UNIT_W(UNIT_W)
) u_chk (.*);

// File: tb/sim_ecc_chunk_engine.sv
`timescale 1ns/1ps
module sim_ecc_chunk_engine;

  localparam int IDX_W = 8, UNITS = 8, PAR_W = 24, UNIT_W = 3, CHUNK = 256;

  logic              clk = 1'b0;
  logic              rstN;
  logic              inValid, inLast;
  logic [7:0]        inData;
  logic [PAR_W-1:0]  storedParity;
  logic              resultValid;
  logic [PAR_W-1:0]  parityOut;
  logic [1:0]        status;
  logic [IDX_W-1:0]  errByte;
  logic [2:0]        errBit;
  logic [UNIT_W-1:0] resultUnit;

  always #2 clk = ~clk;  // 250 MHz

  ecc_chunk_engine u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inLast(inLast),
    .storedParity(storedParity), .resultValid(resultValid), .parityOut(parityOut),
    .status(status), .errByte(errByte), .errBit(errBit), .resultUnit(resultUnit)
  );

  typedef struct packed {
    logic [7:0]  seed;
    logic        aEn;  logic [10:0] aPos;   // {byte, bit}
    logic        bEn;  logic [10:0] bPos;
    logic        pEn;  logic [4:0]  pBit;
    logic        gaps;
    logic        padZero;
    logic [1:0]  expSt;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{8'h5A, 1'b0, 11'd0,               1'b0, 11'd0,               1'b0, 5'd0,  1'b0, 1'b0, 2'd0}, // R4
    '{8'h13, 1'b1, {8'd0,   3'd0},      1'b0, 11'd0,               1'b0, 5'd0,  1'b0, 1'b0, 2'd1}, // R5 first bit
    '{8'hC3, 1'b1, {8'd255, 3'd7},      1'b0, 11'd0,               1'b0, 5'd0,  1'b0, 1'b0, 2'd1}, // R5 last bit
    '{8'h77, 1'b1, {8'h9C,  3'd5},      1'b0, 11'd0,               1'b0, 5'd0,  1'b0, 1'b0, 2'd1}, // R5 middle
    '{8'h21, 1'b0, 11'd0,               1'b0, 11'd0,               1'b1, 5'd0,  1'b0, 1'b0, 2'd2}, // R6
    '{8'h44, 1'b0, 11'd0,               1'b0, 11'd0,               1'b1, 5'd21, 1'b0, 1'b0, 2'd2}, // R6
    '{8'h99, 1'b1, {8'd3,   3'd1},      1'b1, {8'd3,   3'd6},      1'b0, 5'd0,  1'b0, 1'b0, 2'd3}, // R7 same byte
    '{8'hE8, 1'b1, {8'd10,  3'd2},      1'b1, {8'd200, 3'd2},      1'b0, 5'd0,  1'b0, 1'b0, 2'd3}, // R7 same column
    '{8'h31, 1'b1, {8'd50,  3'd4},      1'b0, 11'd0,               1'b1, 5'd9,  1'b0, 1'b0, 2'd3}, // R7 data+parity
    '{8'h0F, 1'b0, 11'd0,               1'b0, 11'd0,               1'b0, 5'd0,  1'b1, 1'b0, 2'd0}, // R11 gaps
    '{8'h66, 1'b0, 11'd0,               1'b0, 11'd0,               1'b0, 5'd0,  1'b0, 1'b1, 2'd0}  // R8 pad zero
  };

  int checks = 0, fails = 0;
  int unitExp = 0;
  bit done = 0;
  logic [7:0] work [CHUNK];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input logic [7:0] seed, input int i);
    logic [7:0] idx = 8'(i);
    return (idx * 8'd37) ^ seed ^ {idx[2:0], idx[7:3]};
  endfunction

  // reference code straight from the R2 bit definitions
  function automatic logic [23:0] golden();
    logic [23:0] p = 24'hC0_0000;
    for (int i = 0; i < CHUNK; i++)
      for (int b = 0; b < 8; b++)
        if (work[i][b]) begin
          for (int k = 0; k < 8; k++)
            if (((i >> k) & 1) == 1) p[2*k+1] ^= 1'b1; else p[2*k] ^= 1'b1;
          for (int j = 0; j < 3; j++)
            if (((b >> j) & 1) == 1) p[17+2*j] ^= 1'b1; else p[16+2*j] ^= 1'b1;
        end
    return p;
  endfunction

  task automatic sendChunk(input logic gaps);
    for (int i = 0; i < CHUNK; i++) begin
      if (gaps && (i % 16 == 7)) begin
        @(negedge clk); inValid = 1'b0; inData = 8'hFF; inLast = 1'b1;  // R11 ignored cycle
      end
      @(negedge clk); inValid = 1'b1; inData = work[i]; inLast = (i == CHUNK - 1);
    end
    @(negedge clk); inValid = 1'b0; inLast = 1'b0; inData = 8'h00;
  endtask

  task automatic runRow(input vec_t v, input string tag);
    logic [23:0] clean, expPar, held;
    for (int i = 0; i < CHUNK; i++) work[i] = gen(v.seed, i);
    clean = golden();
    if (v.aEn) work[v.aPos[10:3]][v.aPos[2:0]] ^= 1'b1;
    if (v.bEn) work[v.bPos[10:3]][v.bPos[2:0]] ^= 1'b1;
    expPar = golden();
    storedParity = clean ^ (v.pEn ? (24'd1 << v.pBit) : 24'd0);
    if (v.padZero) storedParity[23:22] = 2'b00;
    sendChunk(v.gaps);
    check({tag, " R3 pulse"}, 32'(resultValid), 32'd1);
    check({tag, " R2 R9 parity word"}, 32'(parityOut), 32'(expPar));
    check({tag, " R4-class status (R5 R6 R7 R8 R11)"}, 32'(status), 32'(v.expSt));
    check({tag, " R5 errByte"}, 32'(errByte), (v.expSt == 2'd1) ? 32'(v.aPos[10:3]) : 32'd0);
    check({tag, " R5 errBit"}, 32'(errBit), (v.expSt == 2'd1) ? 32'(v.aPos[2:0]) : 32'd0);
    check({tag, " R10 unit"}, 32'(resultUnit), 32'(unitExp));
    unitExp = (unitExp + 1) % UNITS;
    held = parityOut;
    @(negedge clk);
    check({tag, " R3 single-cycle pulse"}, 32'(resultValid), 32'd0);
    check({tag, " R3 hold"}, 32'(parityOut), 32'(held));
  endtask

  initial begin
    rstN = 1'b0; inValid = 1'b0; inLast = 1'b0; inData = 8'h00; storedParity = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(resultValid), 32'd0);
    check("R1 reset parity", 32'(parityOut), 32'd0);
    check("R1 reset status", 32'(status), 32'd0);
    check("R1 reset unit", 32'(resultUnit), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int r = 0; r < NVEC; r++) runRow(VECS[r], $sformatf("vec%0d", r));

    // R1: reset in the middle of a chunk discards it and rewinds the unit count
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); inValid = 1'b1; inData = 8'(i * 7 + 1); inLast = 1'b0;
    end
    @(negedge clk); inValid = 1'b0; rstN = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset valid", 32'(resultValid), 32'd0);
    check("R1 mid-run reset unit", 32'(resultUnit), 32'd0);
    rstN = 1'b1;
    unitExp = 0;
    runRow(VECS[0], "after-reset R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule